// File: doc/BRIEF.md
# Output Register Cell with Single- and Double-Rate Modes

This cell sits between core logic and an output pad driver. It takes two data words from the core and presents one word to the pad. In single-rate mode one storage element drives the pad. That element can be an edge-triggered flip-flop or a level-sensitive latch, and it honours a clock enable and a synchronous reset.

In double-rate mode the primary element is always an edge register and captures the rise-path word on each rising edge. A second latch holds the fall-path word. This latch has no enable and no reset. It is transparent while the clock is high and holds while the clock is low. A multiplexer steered by the clock itself shows the rise register during the high phase and the held fall word during the low phase, so two words leave the cell in every clock period.

The mode pins are static. They are copied into the cell only while reset is active.

Top module: `oreg_cell`

## Requirements
- R1: When reset is active at a rising edge, the primary element reads 0 after that edge, whatever `ce` is. In latch mode it also reads 0 while the clock is high under reset. The active level is set by parameter `RST_ACTIVE_HIGH`, which defaults to 1 (active high).
- R2: `mode_ddr` and `mode_latch` are captured only at rising edges while reset is active. Changing them outside reset does not change the behaviour.
- R3: In single-rate flop mode (`mode_ddr`=0, `mode_latch`=0) with `ce`=1, `pad_q` takes `d_rise` at the rising edge. It keeps that value for the whole period even if `d_rise` changes.
- R4: In single-rate flop mode with `ce`=0, `pad_q` keeps its value across a rising edge.
- R5: In single-rate latch mode (`mode_ddr`=0, `mode_latch`=1) with `ce`=1, `pad_q` follows `d_rise` while the clock is high. While the clock is low it holds the value seen at the falling edge.
- R6: In latch mode with `ce`=0, `pad_q` holds even while the clock is high.
- R7: In double-rate mode (`mode_ddr`=1), `pad_q` shows the rise register during the high phase. That register loads `d_rise` at the rising edge when `ce`=1 and holds when `ce`=0.
- R8: In double-rate mode, `pad_q` shows during the low phase the `d_fall` value present at the falling edge. Changes of `d_fall` during the low phase do not reach `pad_q`.
- R9: In double-rate mode the fall path ignores reset and `ce`. Under reset the high phase shows 0 while the low phase still shows `d_fall`.
- R10: In double-rate mode `mode_latch` has no effect. The rise path is edge-captured, so changes of `d_rise` after the rising edge do not reach `pad_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock; also the output mux select |
| ce | input | 1 | Clock enable for the primary element |
| srst | input | 1 | Synchronous reset, level per `RST_ACTIVE_HIGH` |
| mode_ddr | input | 1 | 1 selects double-rate mode (captured during reset) |
| mode_latch | input | 1 | 1 makes the single-rate element a latch (captured during reset) |
| d_rise | input | WIDTH | Core word for the primary element |
| d_fall | input | WIDTH | Core word for the double-rate fall path |
| pad_q | output | WIDTH | Word to the pad driver |

## Verification
Reset can land in the same clock period as a double-rate transfer. The two paths then have to act independently: the high phase must show the cleared rise register, while the low phase must still carry the fall word, because the fall latch has no reset. The bench asserts reset and also drops `ce`, with a distinctive fall word in double-rate mode. It samples two nanoseconds into each phase and expects 0 in the high half and the fall word in the low half. A second case changes `d_fall` right after the falling edge and expects the low half to keep the older word.

// File: rtl/oreg_pkg.sv
package oreg_pkg;

   typedef enum logic [1:0] {
      OM_SDR_FLOP  = 2'd0,
      OM_SDR_LATCH = 2'd1,
      OM_DDR       = 2'd2
   } oreg_mode_e;

   function automatic oreg_mode_e oreg_decode(input logic ddr, input logic lat,
                                              input logic ddr_ok, input logic lat_ok);
      if (ddr && ddr_ok)      return OM_DDR;
      else if (lat && lat_ok) return OM_SDR_LATCH;
      else                    return OM_SDR_FLOP;
   endfunction

endpackage

// File: rtl/oreg_mode_capture.sv
module oreg_mode_capture
   import oreg_pkg::*;
#(
   parameter bit HAS_DDR   = 1'b1,
   parameter bit HAS_LATCH = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       ddr_pin,
   input  logic       latch_pin,
   output oreg_mode_e mode
);

   always_ff @(posedge clk) begin
      if (rst) mode <= oreg_decode(ddr_pin, latch_pin, HAS_DDR, HAS_LATCH);
   end

   // R2: mode is frozen outside reset
   p_mode_frozen_r2: assert property (@(posedge clk) disable iff (rst)
      !rst |=> $stable(mode));

endmodule

// File: rtl/oreg_primary.sv
module oreg_primary #(
   parameter int WIDTH     = 1,
   parameter bit HAS_LATCH = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ce,
   input  logic             use_latch,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] flop_q;

   always_ff @(posedge clk) begin
      if (rst)     flop_q <= '0;
      else if (ce) flop_q <= d;
   end

   generate
      if (HAS_LATCH) begin : g_latch
         logic [WIDTH-1:0] lat_q;
         always_latch begin
            if (clk && (rst || ce)) lat_q = rst ? '0 : d;
         end
         assign q = use_latch ? lat_q : flop_q;
      end else begin : g_flop_only
         assign q = flop_q;
      end
   endgenerate

   // R1: reset clears the edge register regardless of enable
   p_rst_clear_r1: assert property (@(posedge clk)
      rst |=> (flop_q == '0));

   // R3: enabled edge register loads the input of the previous edge
   p_load_r3: assert property (@(posedge clk) disable iff (rst)
      ce |=> (flop_q == $past(d)));

   // R4: disabled edge register holds
   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !ce |=> $stable(flop_q));

endmodule

// File: rtl/oreg_fall_latch.sv
module oreg_fall_latch #(
   parameter int WIDTH = 1
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_latch begin
      if (clk) q = d;
   end

   logic             seen_fall = 1'b0;
   logic [WIDTH-1:0] fall_snap;

   always_ff @(negedge clk) begin
      fall_snap <= d;
      seen_fall <= 1'b1;
   end

   // R8: through the low phase the latch keeps the word seen at the falling edge
   p_low_hold_r8: assert property (@(posedge clk) disable iff (!seen_fall)
      q == fall_snap);

endmodule

// File: rtl/oreg_cell.sv
module oreg_cell
   import oreg_pkg::*;
#(
   parameter int WIDTH           = 1,
   parameter bit RST_ACTIVE_HIGH = 1'b1,
   parameter bit HAS_DDR         = 1'b1,
   parameter bit HAS_LATCH       = 1'b1
) (
   input  logic             clk,
   input  logic             ce,
   input  logic             srst,
   input  logic             mode_ddr,
   input  logic             mode_latch,
   input  logic [WIDTH-1:0] d_rise,
   input  logic [WIDTH-1:0] d_fall,
   output logic [WIDTH-1:0] pad_q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("oreg_cell: WIDTH must be at least 1");
      end
   endgenerate

   logic             rst;
   oreg_mode_e       mode;
   logic             use_latch;
   logic             sel_ddr;
   logic [WIDTH-1:0] hi_word;
   logic [WIDTH-1:0] lo_word;

   assign rst       = RST_ACTIVE_HIGH ? srst : !srst;
   assign use_latch = (mode == OM_SDR_LATCH);
   assign sel_ddr   = (mode == OM_DDR);

   oreg_mode_capture #(.HAS_DDR(HAS_DDR), .HAS_LATCH(HAS_LATCH)) u_mode (
      .clk(clk), .rst(rst), .ddr_pin(mode_ddr), .latch_pin(mode_latch), .mode(mode)
   );

   oreg_primary #(.WIDTH(WIDTH), .HAS_LATCH(HAS_LATCH)) u_prim (
      .clk(clk), .rst(rst), .ce(ce), .use_latch(use_latch), .d(d_rise), .q(hi_word)
   );

   generate
      if (HAS_DDR) begin : g_ddr
         oreg_fall_latch #(.WIDTH(WIDTH)) u_fall (
            .clk(clk), .d(d_fall), .q(lo_word)
         );
      end else begin : g_sdr_only
         assign lo_word = '0;
      end
   endgenerate

   assign pad_q = (sel_ddr && !clk) ? lo_word : hi_word;

   // R7: in double-rate mode an enabled edge loads the rise word
   p_ddr_rise_r7: assert property (@(posedge clk) disable iff (rst)
      (sel_ddr && ce) |=> (u_prim.flop_q == $past(d_rise)));

endmodule

// File: tb/tb_oreg_cell.sv
module tb_oreg_cell;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         ce = 1'b0;
   logic         srst = 1'b1;
   logic         mode_ddr = 1'b0;
   logic         mode_latch = 1'b0;
   logic [W-1:0] d_rise = '0;
   logic [W-1:0] d_fall = '0;
   logic [W-1:0] pad_q;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   oreg_cell #(.WIDTH(W)) dut (
      .clk(clk), .ce(ce), .srst(srst), .mode_ddr(mode_ddr), .mode_latch(mode_latch),
      .d_rise(d_rise), .d_fall(d_fall), .pad_q(pad_q)
   );

   // {ce, rise word, fall word}
   localparam logic [8:0] VEC [8] = '{
      {1'b1, 4'h5, 4'hA}, {1'b1, 4'hA, 4'h5}, {1'b1, 4'hF, 4'h0}, {1'b0, 4'h3, 4'hC},
      {1'b0, 4'h9, 4'h6}, {1'b1, 4'h0, 4'hF}, {1'b1, 4'h7, 4'h8}, {1'b1, 4'hE, 4'h1}
   };

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset(input logic ddr, input logic lat);
      @(negedge clk); #1;
      srst = 1'b1; mode_ddr = ddr; mode_latch = lat;
      repeat (2) @(posedge clk);
      @(negedge clk); #1;
      srst = 1'b0;
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
      $finish;
   end

   initial begin
      logic [W-1:0] prim;
      logic [W-1:0] prev_b;

      // single-rate flop mode
      do_reset(1'b0, 1'b0);
      ce = 1'b0; #1;
      chk("R1", pad_q, 4'h0);
      ce = 1'b1; d_rise = 4'h6;
      @(posedge clk); #2;
      chk("R3", pad_q, 4'h6);
      d_rise = 4'h1;
      @(negedge clk); #2;
      chk("R3", pad_q, 4'h6);
      ce = 1'b0; d_rise = 4'h2;
      @(posedge clk); #2;
      chk("R4", pad_q, 4'h6);
      srst = 1'b1;
      @(posedge clk); #2;
      chk("R1", pad_q, 4'h0);
      srst = 1'b0;

      // single-rate latch mode
      do_reset(1'b0, 1'b1);
      #1;
      chk("R1", pad_q, 4'h0);
      ce = 1'b1; d_rise = 4'h5; #1;
      chk("R5", pad_q, 4'h0);
      @(posedge clk); #1;
      chk("R5", pad_q, 4'h5);
      d_rise = 4'h9; #1;
      chk("R5", pad_q, 4'h9);
      @(negedge clk); #2;
      chk("R5", pad_q, 4'h9);
      d_rise = 4'h3; #1;
      chk("R5", pad_q, 4'h9);
      ce = 1'b0;
      @(posedge clk); #2;
      chk("R6", pad_q, 4'h9);
      d_rise = 4'h4; #1;
      chk("R6", pad_q, 4'h9);

      // double-rate table walk
      do_reset(1'b1, 1'b0);
      prim = '0;
      prev_b = '0;
      for (int i = 0; i < 8; i++) begin
         ce = VEC[i][8]; d_rise = VEC[i][7:4]; d_fall = VEC[i][3:0];
         if (i > 0) begin
            #1;
            chk("R8", pad_q, prev_b);
         end
         @(posedge clk); #2;
         if (VEC[i][8]) prim = VEC[i][7:4];
         chk("R7", pad_q, prim);
         @(negedge clk); #2;
         chk("R8", pad_q, VEC[i][3:0]);
         prev_b = VEC[i][3:0];
      end

      // mode pins outside reset
      mode_ddr = 1'b0; mode_latch = 1'b1;
      ce = 1'b1; d_rise = 4'h2; d_fall = 4'hB;
      @(posedge clk); #2;
      chk("R2", pad_q, 4'h2);
      @(negedge clk); #2;
      chk("R2", pad_q, 4'hB);

      // reset and enable against the fall path in the same period
      mode_ddr = 1'b1; mode_latch = 1'b0;
      srst = 1'b1; ce = 1'b1; d_rise = 4'hF; d_fall = 4'hA;
      @(posedge clk); #2;
      chk("R9", pad_q, 4'h0);
      @(negedge clk); #2;
      chk("R9", pad_q, 4'hA);
      ce = 1'b0; d_fall = 4'h5;
      @(posedge clk); #2;
      chk("R9", pad_q, 4'h0);
      @(negedge clk); #2;
      chk("R9", pad_q, 4'h5);
      srst = 1'b0;

      // latch option ignored in double-rate mode
      do_reset(1'b1, 1'b1);
      ce = 1'b1; d_rise = 4'h3; d_fall = 4'h6;
      @(posedge clk); #1;
      d_rise = 4'hC; #1;
      chk("R10", pad_q, 4'h3);
      @(negedge clk); #2;
      chk("R10", pad_q, 4'h6);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule